// File: doc/BRIEF.md
# Message-Store DRAM Controller with CAS-before-RAS Refresh

This block runs asynchronous x4 DRAM that holds recorded messages. It serves single-nibble reads and writes requested by the processing core. Each access is a fixed nine-state cycle. The row address goes out with RAS, then the column address goes out with one of four CAS lines, one per device. All devices share RAS, the address bus, the read and write strobes and a 4-bit data bus.

Between accesses the block issues distributed CAS-before-RAS refresh cycles. These are timed in one of two ways:

- In normal run, a programmable divider of the system clock sets the rate. The nominal period is 15.625 us with the reset divisor of 383 at 24.576 MHz.
- While the system is powered down, every transition of the 32.768 kHz oscillator requests a refresh. Both edges count, so the rate is about one request every 15.3 us.

The core sees a busy flag and a read-data register. A pending refresh wins arbitration over a new request but never cuts into a running access. Three address organizations are supported: 1M x4 with 10/10 row/column bits, 4M x4 with 11/11, and 4M x4 with 12/10.

Top module: `dram_msg_ctrl`

## Requirements
- R1: While `rst_n` is low and after its release, `busy`=0, `ras_n`=1, `cas_n`=4'hF, `mrd_n`=1, `mwr_n`=1, `md_oe`=0, `ma`=0, `rd_data`=0, and no refresh is pending.
- R2: An access occupies nine states T1..T9, one clock each, with `busy` high throughout. RAS is low in T2..T8. Only `cas_n[d]` is low, in T5..T8, where d=`req_addr[23:22]`. The other CAS lines stay high.
- R3: `ma` is 0 outside accesses. It carries the row in T1..T3 and T9 and the column in T4..T8. The word is w=`req_addr[21:0]`, and `ma` bits above the field are 0. The field depends on `org`:
  - `org`=0: row w[19:10], column w[9:0].
  - `org`=1: row w[21:11], column w[10:0].
  - `org`=2: row w[21:10], column w[9:0].
  - `org`=3 behaves as 0.
- R4: In a read (`req_we`=0), `mrd_n` is low in T4..T8. `rd_data` takes `md_i` at the clock edge that ends T8 and keeps it until the next read captures.
- R5: In a write (`req_we`=1), `mwr_n` is low in T4..T8 and `md_oe` is high in T3..T8 with `md_o`=`req_wdata`. Both are active before CAS falls in T5. In all other states, the strobes are high and `md_oe` is low.
- R6: A refresh cycle is nine states. All four CAS lines are low in T2..T7 and RAS is low in T3..T8. Throughout, `md_oe`=0, `mrd_n`=`mwr_n`=1 and `ma`=0.
- R7: With `dram_en`=1 and `pwr_down`=0, a refresh request is raised once every divisor+1 clocks. The divisor resets to 383 and is loaded from `div_val` on a clock where `div_we`=1. The count restarts when it reaches or exceeds the divisor.
- R8: With `dram_en`=1 and `pwr_down`=1, the divider stays at zero. Each transition of `lf_clk`, rising or falling, raises exactly one request, after a two-stage synchronizer. With no access running, a refresh starts on every lf transition, spaced exactly as the transitions are.
- R9: When the block is idle with a refresh pending, the refresh starts at the next edge and a simultaneous `req` is dropped. `req` is accepted only when idle with nothing pending and is ignored while `busy`. A running cycle always completes all nine states.
- R10: While `dram_en`=0, no refresh request is raised, a pending one is cleared, and no refresh cycle follows.
- R11: After every nine-state cycle, `busy` is low for at least one clock before the next cycle starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dram_en | input | 1 | Enables refresh generation |
| pwr_down | input | 1 | Selects low-frequency refresh timing |
| lf_clk | input | 1 | 32.768 kHz oscillator, sampled |
| div_we | input | 1 | Loads the refresh divisor |
| div_val | input | 10 | New refresh divisor |
| org | input | 2 | Row/column organization select |
| req | input | 1 | Access request, taken when idle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 24 | Device [23:22], word [21:0] |
| req_wdata | input | 4 | Write nibble |
| busy | output | 1 | Cycle in progress |
| rd_data | output | 4 | Last read nibble |
| ras_n | output | 1 | Row strobe, shared |
| cas_n | output | 4 | Column strobe per device |
| ma | output | 12 | Multiplexed address |
| mrd_n | output | 1 | Read strobe |
| mwr_n | output | 1 | Write strobe |
| md_o | output | 4 | Data toward DRAM |
| md_oe | output | 1 | Data bus drive enable |
| md_i | input | 4 | Data from DRAM |

## Verification
The bench builds the block with its default parameters: four devices, 4-bit data, a 12-bit address bus, a 10-bit divisor and a reset divisor of 383. At run time the bench first writes a divisor of 19. With refreshes every 20 clocks, they collide often with back-to-back accesses, which exercises the arbitration and no-interrupt rules in a short run. A later reset brings back the 383 default so its 384-clock spacing can be measured. A 40-clock lf_clk half period exercises both-edge slow refresh. Accesses in all three organizations, with addresses that set the top bits, show each row/column split on `ma`.

// File: rtl/dram_msg_pkg.sv
package dram_msg_pkg;

  typedef enum logic [1:0] {
    CK_IDLE = 2'd0,
    CK_ACC  = 2'd1,
    CK_REF  = 2'd2
  } cyc_kind_e;

  typedef enum logic [1:0] {
    ORG_1M_10X10 = 2'd0,
    ORG_4M_11X11 = 2'd1,
    ORG_4M_12X10 = 2'd2,
    ORG_RSVD     = 2'd3
  } dram_org_e;

  localparam logic [3:0] PH_FIRST = 4'd1;
  localparam logic [3:0] PH_CAP   = 4'd8;
  localparam logic [3:0] PH_LAST  = 4'd9;

endpackage

// File: rtl/refresh_tick_gen.sv
module refresh_tick_gen #(
  parameter int unsigned DIV_W   = 10,
  parameter int unsigned DIV_RST = 383,
  parameter int unsigned SYNC_N  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             slow_sel,
  input  logic             div_we,
  input  logic [DIV_W-1:0] div_val,
  input  logic             lf_clk,
  output logic             tick
);

  localparam int unsigned SH_W = SYNC_N + 1;

  logic [DIV_W-1:0] div_q, div_d, cnt_q, cnt_d;
  logic [SH_W-1:0]  sync_q, sync_d;
  logic             at_top, lf_edge;

  always_comb begin
    sync_d  = {sync_q[SH_W-2:0], lf_clk};
    lf_edge = sync_q[SYNC_N-1] ^ sync_q[SYNC_N];
    at_top  = (cnt_q >= div_q);
    tick    = en & (slow_sel ? lf_edge : at_top);
    cnt_d   = (!en || slow_sel || at_top) ? '0 : cnt_q + DIV_W'(1);
    div_d   = div_we ? div_val : div_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= DIV_W'(DIV_RST);
      cnt_q  <= '0;
      sync_q <= '0;
    end else begin
      div_q  <= div_d;
      cnt_q  <= cnt_d;
      sync_q <= sync_d;
    end
  end

endmodule

// File: rtl/dram_addr_mux.sv
module dram_addr_mux
  import dram_msg_pkg::*;
#(
  parameter int unsigned WORD_W = 22,
  parameter int unsigned MA_W   = 12
) (
  input  dram_org_e          org,
  input  logic [WORD_W-1:0]  word,
  input  logic               drive,
  input  logic               col_sel,
  output logic [MA_W-1:0]    ma
);

  logic [MA_W-1:0] row, col;

  always_comb begin
    case (org)
      ORG_4M_11X11: begin
        row = MA_W'(word[21:11]);
        col = MA_W'(word[10:0]);
      end
      ORG_4M_12X10: begin
        row = MA_W'(word[21:10]);
        col = MA_W'(word[9:0]);
      end
      default: begin
        row = MA_W'(word[19:10]);
        col = MA_W'(word[9:0]);
      end
    endcase
    ma = !drive ? '0 : (col_sel ? col : row);
  end

endmodule

// File: rtl/dram_cycle_seq.sv
module dram_cycle_seq
  import dram_msg_pkg::*;
#(
  parameter int unsigned DEV_N  = 4,
  parameter int unsigned DQ_W   = 4,
  parameter int unsigned WORD_W = 22,
  localparam int unsigned DEV_W = (DEV_N > 1) ? $clog2(DEV_N) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_en,
  input  logic              ref_tick,
  input  logic              req,
  input  logic              req_we,
  input  logic [DEV_W-1:0]  req_dev,
  input  logic [WORD_W-1:0] req_word,
  input  logic [DQ_W-1:0]   req_wdata,
  input  logic [DQ_W-1:0]   md_i,
  output logic              busy,
  output logic [DQ_W-1:0]   rd_data,
  output logic              ras_n,
  output logic [DEV_N-1:0]  cas_n,
  output logic              mrd_n,
  output logic              mwr_n,
  output logic [DQ_W-1:0]   md_o,
  output logic              md_oe,
  output logic              addr_drv,
  output logic              col_sel,
  output logic [WORD_W-1:0] word_o
);

  function automatic logic in_win(input logic [3:0] p, input logic [3:0] lo,
                                  input logic [3:0] hi);
    return (p >= lo) && (p <= hi);
  endfunction

  cyc_kind_e         kind_q, kind_d;
  logic [3:0]        ph_q, ph_d;
  logic              pend_q, pend_d;
  logic              we_q;
  logic [DEV_W-1:0]  dev_q;
  logic [WORD_W-1:0] word_q;
  logic [DQ_W-1:0]   wd_q, rd_q, rd_d;
  logic              acc_on, ref_on, start_ref, start_acc, rd_cap;

  // next state
  always_comb begin
    acc_on    = (kind_q == CK_ACC);
    ref_on    = (kind_q == CK_REF);
    start_ref = (kind_q == CK_IDLE) && pend_q;
    start_acc = (kind_q == CK_IDLE) && !pend_q && req;
    pend_d    = ref_en && ((pend_q && !start_ref) || ref_tick);
    rd_cap    = acc_on && !we_q && (ph_q == PH_CAP);
    rd_d      = rd_cap ? md_i : rd_q;
    kind_d    = kind_q;
    ph_d      = ph_q;
    if (start_ref) begin
      kind_d = CK_REF;
      ph_d   = PH_FIRST;
    end else if (start_acc) begin
      kind_d = CK_ACC;
      ph_d   = PH_FIRST;
    end else if (kind_q != CK_IDLE) begin
      if (ph_q == PH_LAST) begin
        kind_d = CK_IDLE;
        ph_d   = '0;
      end else begin
        ph_d = ph_q + 4'd1;
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q <= CK_IDLE;
      ph_q   <= '0;
      pend_q <= 1'b0;
      rd_q   <= '0;
      we_q   <= 1'b0;
      dev_q  <= '0;
      word_q <= '0;
      wd_q   <= '0;
    end else begin
      kind_q <= kind_d;
      ph_q   <= ph_d;
      pend_q <= pend_d;
      rd_q   <= rd_d;
      if (start_acc) begin
        we_q   <= req_we;
        dev_q  <= req_dev;
        word_q <= req_word;
        wd_q   <= req_wdata;
      end
    end
  end

  // strobes decoded from the state
  always_comb begin
    busy     = (kind_q != CK_IDLE);
    ras_n    = !((acc_on && in_win(ph_q, 4'd2, 4'd8)) ||
                 (ref_on && in_win(ph_q, 4'd3, 4'd8)));
    mrd_n    = !(acc_on && !we_q && in_win(ph_q, 4'd4, 4'd8));
    mwr_n    = !(acc_on &&  we_q && in_win(ph_q, 4'd4, 4'd8));
    md_oe    = acc_on && we_q && in_win(ph_q, 4'd3, 4'd8);
    md_o     = wd_q;
    addr_drv = acc_on;
    col_sel  = acc_on && in_win(ph_q, 4'd4, 4'd8);
    word_o   = word_q;
    rd_data  = rd_q;
  end

  for (genvar g = 0; g < DEV_N; g++) begin : g_cas
    assign cas_n[g] = !((acc_on && (dev_q == DEV_W'(g)) && in_win(ph_q, 4'd5, 4'd8)) ||
                        (ref_on && in_win(ph_q, 4'd2, 4'd7)));
  end

  // R2
  cas_under_ras_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_on && (cas_n != '1)) |-> !ras_n);
  // R6
  cbr_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_on && $fell(ras_n)) |-> (cas_n == '0));
  // R5
  early_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_on && we_q && !cas_n[dev_q] && ($past(cas_n) == '1)) |-> (!mwr_n && md_oe));
  // R9
  no_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((kind_q != CK_IDLE) && (ph_q != PH_LAST)) |=> (kind_q == $past(kind_q)));
  // R9
  ref_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((kind_q == CK_IDLE) && pend_q) |=> ref_on);
  // R4
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_cap |=> $stable(rd_data));
  // R10
  ref_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_en |=> !pend_q);

endmodule

// File: rtl/dram_msg_ctrl.sv
module dram_msg_ctrl
  import dram_msg_pkg::*;
#(
  parameter int unsigned DEV_N   = 4,
  parameter int unsigned DQ_W    = 4,
  parameter int unsigned MA_W    = 12,
  parameter int unsigned DIV_W   = 10,
  parameter int unsigned DIV_RST = 383,
  localparam int unsigned WORD_W = 22,
  localparam int unsigned DEV_W  = (DEV_N > 1) ? $clog2(DEV_N) : 1,
  localparam int unsigned ADDR_W = WORD_W + DEV_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dram_en,
  input  logic              pwr_down,
  input  logic              lf_clk,
  input  logic              div_we,
  input  logic [DIV_W-1:0]  div_val,
  input  logic [1:0]        org,
  input  logic              req,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DQ_W-1:0]   req_wdata,
  output logic              busy,
  output logic [DQ_W-1:0]   rd_data,
  output logic              ras_n,
  output logic [DEV_N-1:0]  cas_n,
  output logic [MA_W-1:0]   ma,
  output logic              mrd_n,
  output logic              mwr_n,
  output logic [DQ_W-1:0]   md_o,
  output logic              md_oe,
  input  logic [DQ_W-1:0]   md_i
);

  logic              tick, addr_drv, col_sel;
  logic [WORD_W-1:0] word_q;

  refresh_tick_gen #(.DIV_W(DIV_W), .DIV_RST(DIV_RST), .SYNC_N(2)) u_tick (
    .clk(clk), .rst_n(rst_n), .en(dram_en), .slow_sel(pwr_down),
    .div_we(div_we), .div_val(div_val), .lf_clk(lf_clk), .tick(tick)
  );

  dram_cycle_seq #(.DEV_N(DEV_N), .DQ_W(DQ_W), .WORD_W(WORD_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .ref_en(dram_en), .ref_tick(tick),
    .req(req), .req_we(req_we), .req_dev(req_addr[ADDR_W-1 -: DEV_W]),
    .req_word(req_addr[WORD_W-1:0]), .req_wdata(req_wdata), .md_i(md_i),
    .busy(busy), .rd_data(rd_data), .ras_n(ras_n), .cas_n(cas_n),
    .mrd_n(mrd_n), .mwr_n(mwr_n), .md_o(md_o), .md_oe(md_oe),
    .addr_drv(addr_drv), .col_sel(col_sel), .word_o(word_q)
  );

  dram_addr_mux #(.WORD_W(WORD_W), .MA_W(MA_W)) u_mux (
    .org(dram_org_e'(org)), .word(word_q), .drive(addr_drv),
    .col_sel(col_sel), .ma(ma)
  );

  // R3
  ma_narrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (org == 2'd0) |-> (ma[MA_W-1:10] == '0));

endmodule

// File: tb/tb_dram_msg_ctrl.sv
`timescale 1ns/1ps
module tb_dram_msg_ctrl;

  localparam int WD_LIMIT = 60000;

  logic clk = 1'b0;
  logic rst_n, dram_en, pwr_down, lf_clk, div_we, req, req_we;
  logic [9:0]  div_val;
  logic [1:0]  org;
  logic [23:0] req_addr;
  logic [3:0]  req_wdata, md_i, rd_data, md_o, cas_n;
  logic [11:0] ma;
  logic        busy, ras_n, mrd_n, mwr_n, md_oe;

  dram_msg_ctrl dut (
    .clk(clk), .rst_n(rst_n), .dram_en(dram_en), .pwr_down(pwr_down),
    .lf_clk(lf_clk), .div_we(div_we), .div_val(div_val), .org(org),
    .req(req), .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .busy(busy), .rd_data(rd_data), .ras_n(ras_n), .cas_n(cas_n), .ma(ma),
    .mrd_n(mrd_n), .mwr_n(mwr_n), .md_o(md_o), .md_oe(md_oe), .md_i(md_i)
  );

  always #2 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  bit cmp_on = 0;

  always @(posedge clk) cyc++;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    if (cyc == WD_LIMIT) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // ---------------- reference model ----------------
  int m_kind, m_ph, m_cnt, m_div;
  bit m_pend, m_we, s1, s2, s3;
  int m_dev;
  logic [21:0] m_word;
  logic [3:0]  m_wd, m_rd;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_kind = 0; m_ph = 0; m_pend = 0; m_we = 0; m_dev = 0;
      m_word = '0; m_wd = '0; m_rd = '0; m_cnt = 0; m_div = 383;
      s1 = 0; s2 = 0; s3 = 0;
    end else begin
      bit at_top, lf_chg, tick, st_ref, st_acc;
      at_top = (m_cnt >= m_div);
      lf_chg = (s2 != s3);
      tick   = dram_en && (pwr_down ? lf_chg : at_top);
      st_ref = (m_kind == 0) && m_pend;
      st_acc = (m_kind == 0) && !m_pend && req;
      if (m_kind == 1 && !m_we && m_ph == 8) m_rd = md_i;
      if (st_ref) begin
        m_kind = 2; m_ph = 1;
      end else if (st_acc) begin
        m_kind = 1; m_ph = 1; m_we = req_we; m_dev = int'(req_addr[23:22]);
        m_word = req_addr[21:0]; m_wd = req_wdata;
      end else if (m_kind != 0) begin
        if (m_ph == 9) begin m_kind = 0; m_ph = 0; end
        else m_ph++;
      end
      m_pend = dram_en && ((m_pend && !st_ref) || tick);
      m_cnt  = (!dram_en || pwr_down || at_top) ? 0 : m_cnt + 1;
      if (div_we) m_div = int'(div_val);
      s3 = s2; s2 = s1; s1 = lf_clk;
    end
  end

  function automatic logic [11:0] exp_row(input int o, input logic [21:0] w);
    if (o == 1) return 12'(w >> 11);
    if (o == 2) return 12'(w >> 10);
    return 12'((w >> 10) & 22'h3FF);
  endfunction

  function automatic logic [11:0] exp_col(input int o, input logic [21:0] w);
    if (o == 1) return 12'(w & 22'h7FF);
    return 12'(w & 22'h3FF);
  endfunction

  // cycle-by-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (cmp_on && rst_n) begin
      bit acc, rf, e_ras, e_mrd, e_mwr, e_oe;
      logic [3:0]  e_cas;
      logic [11:0] e_ma;
      string tk;
      acc   = (m_kind == 1);
      rf    = (m_kind == 2);
      tk    = rf ? "R6" : "R2";
      e_ras = !((acc && m_ph >= 2 && m_ph <= 8) || (rf && m_ph >= 3 && m_ph <= 8));
      e_cas = 4'hF;
      if (acc && m_ph >= 5 && m_ph <= 8) e_cas[m_dev] = 1'b0;
      if (rf && m_ph >= 2 && m_ph <= 7) e_cas = 4'h0;
      e_ma  = '0;
      if (acc) e_ma = (m_ph >= 4 && m_ph <= 8) ? exp_col(int'(org), m_word)
                                               : exp_row(int'(org), m_word);
      e_mrd = !(acc && !m_we && m_ph >= 4 && m_ph <= 8);
      e_mwr = !(acc &&  m_we && m_ph >= 4 && m_ph <= 8);
      e_oe  = acc && m_we && m_ph >= 3 && m_ph <= 8;
      chk(busy == (m_kind != 0), "R9 R11", "busy", busy, m_kind != 0);
      chk(ras_n == e_ras, tk, "ras_n", ras_n, e_ras);
      chk(cas_n == e_cas, tk, "cas_n", cas_n, e_cas);
      chk(ma == e_ma, "R3", "ma", ma, e_ma);
      chk(mrd_n == e_mrd, "R4", "mrd_n", mrd_n, e_mrd);
      chk(rd_data == m_rd, "R4", "rd_data", rd_data, m_rd);
      chk(mwr_n == e_mwr, "R5", "mwr_n", mwr_n, e_mwr);
      chk(md_oe == e_oe, "R5", "md_oe", md_oe, e_oe);
      if (e_oe) chk(md_o == m_wd, "R5", "md_o", md_o, m_wd);
    end
  end

  // refresh-start detector on the pins
  int  ref_cnt = 0, last_start = 0, last_iv = 0;
  bit  prev_all0 = 0;
  always @(negedge clk) begin
    if (rst_n && cas_n == 4'h0 && !prev_all0) begin
      ref_cnt++;
      last_iv    = cyc - last_start;
      last_start = cyc;
    end
    prev_all0 = rst_n && (cas_n == 4'h0);
  end

  // stimulus helpers
  always @(negedge clk) md_i = 4'(cyc * 5 + 1);

  bit lf_run = 0;
  int lf_cnt = 0;
  always @(negedge clk) begin
    if (lf_run) begin
      if (lf_cnt == 39) begin lf_clk = ~lf_clk; lf_cnt = 0; end
      else lf_cnt++;
    end
  end

  task automatic access(input bit we, input logic [23:0] a, input logic [3:0] d);
    @(negedge clk);
    while (busy) @(negedge clk);
    req = 1'b1; req_we = we; req_addr = a; req_wdata = d;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic measure_iv(input int exp, input string tag);
    int n0;
    n0 = ref_cnt;
    while (ref_cnt < n0 + 3) @(negedge clk);
    chk(last_iv == exp, tag, "refresh interval", last_iv, exp);
  endtask

  task automatic reset_checks();
    chk(busy == 1'b0, "R1", "busy in reset", busy, 0);
    chk(ras_n == 1'b1, "R1", "ras_n in reset", ras_n, 1);
    chk(cas_n == 4'hF, "R1", "cas_n in reset", cas_n, 4'hF);
    chk(md_oe == 1'b0 && mrd_n && mwr_n, "R1", "strobes in reset", {md_oe, mrd_n, mwr_n}, 3'b011);
    chk(rd_data == 4'h0, "R1", "rd_data in reset", rd_data, 0);
    chk(ma == 12'h0, "R1", "ma in reset", ma, 0);
  endtask

  initial begin
    int n0;
    rst_n = 0; dram_en = 0; pwr_down = 0; lf_clk = 0; div_we = 0; div_val = '0;
    org = 2'd0; req = 0; req_we = 0; req_addr = '0; req_wdata = '0;
    repeat (4) @(negedge clk);
    reset_checks();
    rst_n = 1;
    cmp_on = 1;

    // R2 R3 R4 R5: accesses in each organization, refresh off
    for (int o = 0; o < 4; o++) begin
      org = 2'(o);
      access(1'b1, {2'(o), 22'h2AA555}, 4'hA);
      access(1'b0, {2'(o), 22'h2AA555}, 4'h0);
      access(1'b1, {2'(3 - o), 22'h3FFFFF}, 4'h5);
      access(1'b0, {2'(3 - o), 22'h155AAA}, 4'h0);
      access(1'b0, {2'(o), 22'h000401}, 4'h0);
    end
    org = 2'd1;

    // R10: never enabled, no refresh
    n0 = ref_cnt;
    repeat (100) @(negedge clk);
    chk(ref_cnt == n0, "R10", "refreshes while disabled", ref_cnt - n0, 0);

    // R7: divisor 19 gives a 20-clock period
    @(negedge clk); div_we = 1; div_val = 10'd19;
    @(negedge clk); div_we = 0; dram_en = 1;
    measure_iv(20, "R7");

    // R9: back-to-back accesses against frequent refresh
    for (int i = 0; i < 16; i++) begin
      org = 2'(i % 3);
      access(i[0], {2'(i), 22'(i * 32'h1357B)}, 4'(i));
    end
    org = 2'd2;
    measure_iv(20, "R9");

    // R10: disabling stops refresh
    dram_en = 0;
    repeat (20) @(negedge clk);
    n0 = ref_cnt;
    repeat (200) @(negedge clk);
    chk(ref_cnt == n0, "R10", "refreshes after disable", ref_cnt - n0, 0);

    // R8: low-frequency mode, both lf edges
    pwr_down = 1; dram_en = 1; lf_run = 1;
    measure_iv(40, "R8");
    access(1'b1, {2'd1, 22'h0ABCDE}, 4'h9);
    access(1'b0, {2'd1, 22'h0ABCDE}, 4'h0);
    measure_iv(40, "R8");
    lf_run = 0; pwr_down = 0; dram_en = 0;
    repeat (20) @(negedge clk);

    // R1 again, then R7 reset divisor 383
    rst_n = 0;
    repeat (2) @(negedge clk);
    reset_checks();
    rst_n = 1;
    dram_en = 1;
    measure_iv(384, "R7");

    repeat (5) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule